// File: doc/BRIEF.md
# I2C Master Command and Data Queue Front End

This block sits between a host register port and the bit-level engine of an I2C master. The host queues command words by writing a shared data/command register: each word carries a data byte, a read-request bit and a stop-after bit, and it is queued only when its push strobe is set. The engine draws the queued commands through a valid/ready handshake. It hands back received bytes, which wait in a receive queue until the host pops them through the same register.

Two interrupt flags track queue occupancy against programmable thresholds and clear themselves when the level moves back. Four error flags latch until the host clears them: transmit overflow, receive underflow, receive overflow and transfer abort. The raw flags are always readable. A mask register decides which flags drive the interrupt line. A user abort holds back new commands until the engine is idle. It then flushes the transmit queue and raises the abort flag. A NACK or a lost arbitration reported by the engine has the same effect. The transmit queue stays flushed and refuses pushes until software clears the abort flag. A separate enable-status bit reports the real on/off state, which trails the enable bit on disable until the engine is idle.

Top module: `i2cq_frontend`

## Requirements
- R1: A write to DCMD (address 1) enters the transmit queue only when bit 10 (push) is set. Queued words reach the engine in order on cmd_byte (bits 7:0), cmd_rd (bit 8, 1 = read request) and cmd_stop (bit 9).
- R2: A push while the transmit queue holds DEPTH words drops the word and sets TX_OVER (ISTAT bit 0).
- R3: A DCMD write with bit 11 (pop) removes the oldest received byte, and a DCMD read then returns it in bits 7:0. A pop of an empty queue sets RX_UNDER (ISTAT bit 1) and leaves the returned byte unchanged.
- R4: A received byte that arrives while the receive queue is full is dropped and sets RX_OVER (ISTAT bit 2).
- R5: RX_FULL (ISTAT bit 4) is high exactly while the receive level is greater than the receive threshold (THRESH bits 2:0).
- R6: TX_EMPTY (ISTAT bit 5) is high exactly while the transmit level is at or below the transmit threshold (THRESH bits 10:8).
- R7: Writing 1 to CTRL bit 1 (abort) stops new commands from being presented. Once eng_idle is high, the block flushes the transmit queue, sets TX_ABRT (ISTAT bit 3) with the user cause (STATUS bit 8), and the abort bit reads back 0.
- R8: A pulse on eng_nack or eng_arb_lost flushes the transmit queue and sets TX_ABRT, with cause STATUS bit 9 (NACK) or bit 10 (arbitration).
- R9: While TX_ABRT is set, the transmit queue stays empty, pushes are dropped without TX_OVER, and no command is presented. Writing ICLR (address 5) bit 3 releases it.
- R10: ISTAT (address 3) shows raw flags whatever the mask. irq is high when any flag is set together with its IMASK (address 4) bit.
- R11: One ICLR write of all ones clears all four latched flags (ISTAT bits 3:0) at once.
- R12: CTRL bit 0 is the enable. Enable-status (STATUS bit 4) rises one cycle after enable is set. After disable it falls only in a cycle where eng_idle is high. Commands are presented only while enable-status is set.
- R13: STATUS bits 0..3 give TX-not-full, TX-empty, RX-not-empty and busy. LEVELS (address 7) gives the transmit level in bits 7:0 and the receive level in bits 15:8.
- R14: After reset, ISTAT reads 0x20, STATUS reads 0x3, LEVELS reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address (read and write) |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr |
| irq | output | 1 | Masked interrupt |
| cmd_valid | output | 1 | A command is offered to the engine |
| cmd_ready | input | 1 | Engine takes the offered command |
| cmd_byte | output | 8 | Command data byte |
| cmd_rd | output | 1 | Command is a read request |
| cmd_stop | output | 1 | STOP after this byte |
| abort_req | output | 1 | Abort pending; engine should finish and STOP |
| eng_idle | input | 1 | Engine is idle on the bus |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| eng_nack | input | 1 | NACK seen (pulse) |
| eng_arb_lost | input | 1 | Arbitration lost (pulse) |

## Verification
The checker watches, on every cycle, the properties that hold at all times. The transmit level never exceeds the depth, and the queue is empty while the abort flag is set. No command is offered during an abort or without enable-status. Enable-status falls only after an idle engine, the abort bit clears only as the abort flag rises, and a fully masked interrupt stays low. Only the bench scenarios can show the content and ordering of commands, the byte returned after each pop, the exact threshold crossings, and the refusal of pushes followed by their recovery once the abort flag is cleared.

// File: rtl/i2cq_pkg.sv
// Shared register addresses, bit positions and the command word type
// for the I2C queue front end. Assumes a 3-bit register address.
package i2cq_pkg;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_DCMD   = 3'd1,
        RA_THRESH = 3'd2,
        RA_ISTAT  = 3'd3,
        RA_IMASK  = 3'd4,
        RA_ICLR   = 3'd5,
        RA_STATUS = 3'd6,
        RA_LEVELS = 3'd7
    } reg_addr_e;

    localparam int CT_EN    = 0;
    localparam int CT_ABORT = 1;

    localparam int DC_RD   = 8;
    localparam int DC_STOP = 9;
    localparam int DC_PUSH = 10;
    localparam int DC_POP  = 11;

    localparam int TH_TX_LSB = 8;

    localparam int FL_TXOVER  = 0;
    localparam int FL_RXUNDER = 1;
    localparam int FL_RXOVER  = 2;
    localparam int FL_TXABRT  = 3;
    localparam int FL_RXFULL  = 4;
    localparam int FL_TXEMPTY = 5;
    localparam int N_LATCHED  = 4;
    localparam int N_FLAGS    = 6;

    typedef struct packed {
        logic       stop;
        logic       rd;
        logic [7:0] data;
    } cmd_t;

endpackage

// File: rtl/i2cq_fifo.sv
// Synchronous show-ahead FIFO with a level count and a flush input.
// Assumes: push when full and pop when empty are ignored here (the
// caller flags them); flush wins over push and pop.
module i2cq_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic [LW-1:0]    level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [LW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign level   = cnt;
    assign dout    = mem[rp];
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    // Pointer and count update, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/i2cq_irq.sv
// Interrupt flags: four latched error flags with per-bit clear, two
// level flags compared against thresholds, raw view and masked output.
// Assumes: a set event in the same cycle as its clear wins.
module i2cq_irq
    import i2cq_pkg::*;
#(
    parameter int AW = 3,
    localparam int LW = AW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_LATCHED-1:0] set_evt,
    input  logic [N_LATCHED-1:0] clr,
    input  logic [LW-1:0]        tx_level,
    input  logic [LW-1:0]        rx_level,
    input  logic [AW-1:0]        tx_thr,
    input  logic [AW-1:0]        rx_thr,
    input  logic [N_FLAGS-1:0]   mask,
    output logic [N_FLAGS-1:0]   flags,
    output logic                 irq
);
    logic [N_LATCHED-1:0] latched;
    logic                 rx_full_lvl, tx_empty_lvl;

    // Latched error flags: clear on request, set on event.
    always_ff @(posedge clk) begin
        if (!rst_n) latched <= '0;
        else        latched <= (latched & ~clr) | set_evt;
    end

    assign rx_full_lvl  = (rx_level > LW'(rx_thr));
    assign tx_empty_lvl = (tx_level <= LW'(tx_thr));
    assign flags        = {tx_empty_lvl, rx_full_lvl, latched};
    assign irq          = |(flags & mask);
endmodule

// File: rtl/i2cq_ctl.sv
// Enable-status tracking and abort sequencing. A user abort waits for
// an idle engine, then flushes; NACK or arbitration loss flush at once.
// The abort cause bits clear together with the abort flag.
module i2cq_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       abort_set,
    input  logic       eng_idle,
    input  logic       eng_nack,
    input  logic       eng_arb_lost,
    input  logic       abrt_flag,
    input  logic       clr_abrt,
    output logic       en_stat,
    output logic       abort_pend,
    output logic       abrt_evt,
    output logic       flush,
    output logic [2:0] cause
);
    logic abort_done;

    assign abort_done = abort_pend && eng_idle;
    assign abrt_evt   = abort_done || eng_nack || eng_arb_lost;
    assign flush      = abrt_evt || abrt_flag;

    // Enable-status follows enable up at once, down only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)        en_stat <= 1'b0;
        else if (enable)   en_stat <= 1'b1;
        else if (eng_idle) en_stat <= 1'b0;
    end

    // Abort request: set by host, cleared in hardware on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)          abort_pend <= 1'b0;
        else if (abort_done) abort_pend <= 1'b0;
        else if (abort_set)  abort_pend <= 1'b1;
    end

    // Abort cause: cleared with the flag, new causes added on top.
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= (clr_abrt ? 3'b000 : cause)
                             | {eng_arb_lost, eng_nack, abort_done};
    end
endmodule

// File: rtl/i2cq_frontend.sv
// Host-facing queue logic of an I2C master: register decode, transmit
// command queue, receive byte queue, interrupt flags and abort control.
// Assumes: the bus engine pops commands by valid/ready, reports idle,
// and delivers received bytes as single-cycle strobes.
module i2cq_frontend
    import i2cq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        irq,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic [7:0]  cmd_byte,
    output logic        cmd_rd,
    output logic        cmd_stop,
    output logic        abort_req,
    input  logic        eng_idle,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        eng_nack,
    input  logic        eng_arb_lost
);
    logic                 ctrl_en;
    logic [AW-1:0]        tx_thr, rx_thr;
    logic [N_FLAGS-1:0]   mask;
    logic [7:0]           rx_hold;
    logic                 wr_ctrl, wr_dcmd, wr_thr, wr_mask, wr_iclr;
    logic                 push_req, pop_req;
    logic                 tx_push, tx_pop, tx_full, tx_empty;
    logic                 rx_full, rx_empty;
    logic [LW-1:0]        tx_level, rx_level;
    logic [7:0]           rx_dout;
    cmd_t                 tx_din, tx_dout;
    logic                 en_stat, abort_pend, abrt_evt, flush;
    logic [2:0]           cause;
    logic [N_FLAGS-1:0]   flags;
    logic [N_LATCHED-1:0] set_evt, clr;
    logic                 wdata_unused;

    assign wdata_unused = ^host_wdata[31:12];

    // Register write decode.
    assign wr_ctrl = host_wr && (host_addr == RA_CTRL);
    assign wr_dcmd = host_wr && (host_addr == RA_DCMD);
    assign wr_thr  = host_wr && (host_addr == RA_THRESH);
    assign wr_mask = host_wr && (host_addr == RA_IMASK);
    assign wr_iclr = host_wr && (host_addr == RA_ICLR);

    assign push_req = wr_dcmd && host_wdata[DC_PUSH];
    assign pop_req  = wr_dcmd && host_wdata[DC_POP];

    // Host-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            tx_thr  <= '0;
            rx_thr  <= '0;
            mask    <= '0;
        end else begin
            if (wr_ctrl) ctrl_en <= host_wdata[CT_EN];
            if (wr_thr) begin
                tx_thr <= host_wdata[TH_TX_LSB +: AW];
                rx_thr <= host_wdata[0 +: AW];
            end
            if (wr_mask) mask <= host_wdata[N_FLAGS-1:0];
        end
    end

    // Hold the byte removed by the last successful pop.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rx_hold <= '0;
        else if (pop_req && !rx_empty) rx_hold <= rx_dout;
    end

    // Transmit command queue.
    assign tx_din  = '{stop: host_wdata[DC_STOP], rd: host_wdata[DC_RD],
                       data: host_wdata[7:0]};
    assign tx_push = push_req && !flush;
    assign cmd_valid = en_stat && !tx_empty && !abort_pend && !flush;
    assign tx_pop  = cmd_valid && cmd_ready;

    i2cq_fifo #(.DEPTH(DEPTH), .WIDTH($bits(cmd_t))) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (tx_push),
        .din   (tx_din),
        .pop   (tx_pop),
        .dout  (tx_dout),
        .full  (tx_full),
        .empty (tx_empty),
        .level (tx_level)
    );

    assign cmd_byte = tx_dout.data;
    assign cmd_rd   = tx_dout.rd;
    assign cmd_stop = tx_dout.stop;

    // Receive byte queue.
    i2cq_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (1'b0),
        .push  (rx_valid),
        .din   (rx_byte),
        .pop   (pop_req),
        .dout  (rx_dout),
        .full  (rx_full),
        .empty (rx_empty),
        .level (rx_level)
    );

    // Enable-status and abort control.
    i2cq_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (ctrl_en),
        .abort_set    (wr_ctrl && host_wdata[CT_ABORT]),
        .eng_idle     (eng_idle),
        .eng_nack     (eng_nack),
        .eng_arb_lost (eng_arb_lost),
        .abrt_flag    (flags[FL_TXABRT]),
        .clr_abrt     (clr[FL_TXABRT]),
        .en_stat      (en_stat),
        .abort_pend   (abort_pend),
        .abrt_evt     (abrt_evt),
        .flush        (flush),
        .cause        (cause)
    );
    assign abort_req = abort_pend;

    // Error events and clear vector for the flag block.
    always_comb begin
        set_evt             = '0;
        set_evt[FL_TXOVER]  = push_req && tx_full && !flush;
        set_evt[FL_RXUNDER] = pop_req && rx_empty;
        set_evt[FL_RXOVER]  = rx_valid && rx_full;
        set_evt[FL_TXABRT]  = abrt_evt;
        clr = wr_iclr ? host_wdata[N_LATCHED-1:0] : '0;
    end

    i2cq_irq #(.AW(AW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (set_evt),
        .clr      (clr),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (tx_thr),
        .rx_thr   (rx_thr),
        .mask     (mask),
        .flags    (flags),
        .irq      (irq)
    );

    // Register read multiplexer.
    always_comb begin
        host_rdata = '0;
        case (reg_addr_e'(host_addr))
            RA_CTRL:   host_rdata[1:0] = {abort_pend, ctrl_en};
            RA_DCMD:   host_rdata[7:0] = rx_hold;
            RA_THRESH: begin
                host_rdata[TH_TX_LSB +: AW] = tx_thr;
                host_rdata[0 +: AW]         = rx_thr;
            end
            RA_ISTAT:  host_rdata[N_FLAGS-1:0] = flags;
            RA_IMASK:  host_rdata[N_FLAGS-1:0] = mask;
            RA_STATUS: begin
                host_rdata[0]    = !tx_full;
                host_rdata[1]    = tx_empty;
                host_rdata[2]    = !rx_empty;
                host_rdata[3]    = en_stat && (!eng_idle || !tx_empty);
                host_rdata[4]    = en_stat;
                host_rdata[10:8] = cause;
            end
            RA_LEVELS: begin
                host_rdata[7:0]  = 8'(tx_level);
                host_rdata[15:8] = 8'(rx_level);
            end
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2cq_checker.sv
// Cycle-by-cycle properties of the queue front end, bound to the top.
module i2cq_checker #(
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic [5:0]    flags,
    input logic [5:0]    mask,
    input logic          irq,
    input logic          cmd_valid,
    input logic          en_stat,
    input logic          eng_idle,
    input logic          abort_pend,
    input logic          rx_valid
);
    AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH)); // R2
    AST_ABRT_KEEPS_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
        flags[3] |-> tx_level == '0); // R9
    AST_NO_CMD_IN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[3] || abort_pend) |-> !cmd_valid); // R7
    AST_CMD_NEEDS_ENSTAT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> en_stat); // R12
    AST_ENSTAT_FALLS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_stat) |-> $past(eng_idle)); // R12
    AST_ABORT_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(abort_pend) |-> flags[3]); // R7
    AST_MASKED_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R10
    AST_RX_OVER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_level == LW'(DEPTH)) |=> flags[2]); // R4
endmodule

bind i2cq_frontend i2cq_checker #(.DEPTH(DEPTH)) u_i2cq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .flags      (flags),
    .mask       (mask),
    .irq        (irq),
    .cmd_valid  (cmd_valid),
    .en_stat    (en_stat),
    .eng_idle   (eng_idle),
    .abort_pend (abort_pend),
    .rx_valid   (rx_valid)
);

// File: tb/test_i2cq_frontend.sv
// Scoreboard bench: push tasks queue expected commands, a monitor
// compares each command the engine model accepts.
module test_i2cq_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq, cmd_valid, cmd_rd, cmd_stop, abort_req;
    logic [7:0]  cmd_byte;
    logic        cmd_ready = 1'b0;
    logic        eng_idle = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        eng_nack = 1'b0;
    logic        eng_arb_lost = 1'b0;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [9:0] expq[$];

    always #10 clk = ~clk;

    i2cq_frontend i_i2cq_frontend (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        host_addr = a; #1; d = host_rdata;
    endtask

    task automatic push_cmd(input logic [7:0] b, input logic r, input logic s);
        expq.push_back({s, r, b});
        wr(3'd1, (32'd1 << 10) | (32'(s) << 9) | (32'(r) << 8) | 32'(b));
    endtask

    task automatic rx_in(input logic [7:0] b);
        @(posedge clk); #1; rx_valid = 1'b1; rx_byte = b;
        @(posedge clk); #1; rx_valid = 1'b0;
    endtask

    task automatic drain();
        @(posedge clk); #1; cmd_ready = 1'b1;
        repeat (DRAIN_CYC) @(posedge clk);
        #1; cmd_ready = 1'b0;
    endtask
    localparam int DRAIN_CYC = 12;

    // Monitor: compare every accepted command with the expected queue (R1).
    always @(negedge clk) begin
        if (rst_n && cmd_valid && cmd_ready) begin
            if (expq.size() == 0) check("R1 unexpected command", {22'd0, cmd_stop, cmd_rd, cmd_byte}, 32'h3ff);
            else check("R1 command order/content", {22'd0, cmd_stop, cmd_rd, cmd_byte}, {22'd0, expq.pop_front()});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk); #1 rst_n = 1'b1;
        // R14 reset state
        rd(3'd3, v); check("R14 ISTAT", v, 32'h20);
        rd(3'd6, v); check("R14 STATUS", v, 32'h3);
        rd(3'd7, v); check("R14 LEVELS", v, 32'h0);
        check("R14 irq", 32'(irq), 32'h0);

        // R1 no push bit: nothing queued
        wr(3'd1, 32'h0000_0155);
        rd(3'd7, v); check("R1 no push level", v, 32'h0);
        push_cmd(8'h11, 1'b0, 1'b0);
        push_cmd(8'h22, 1'b1, 1'b0);
        push_cmd(8'h33, 1'b1, 1'b1);
        @(posedge clk); #1 cmd_ready = 1'b1;
        @(negedge clk);
        check("R12 no command while disabled", 32'(cmd_valid), 32'h0);
        wr(3'd0, 32'h1);
        rd(3'd6, v); check("R12 enable-status not yet", 32'(v[4]), 32'h0);
        @(posedge clk); #1;
        cmd_ready = 1'b0;
        rd(3'd6, v); check("R12 enable-status up", 32'(v[4]), 32'h1);
        drain();
        check("R1 all commands seen", 32'(expq.size()), 32'h0);

        // R2 overflow
        for (int i = 0; i < 8; i++) push_cmd(8'(8'h40 + i), 1'b0, 1'(i == 7));
        wr(3'd1, (32'd1 << 10) | 32'h99);
        rd(3'd3, v); check("R2 TX_OVER", 32'(v[0]), 32'h1);
        rd(3'd7, v); check("R13 tx level full", v, 32'h8);
        rd(3'd6, v); check("R13 TX-not-full low", 32'(v[0]), 32'h0);
        drain();
        check("R2 overflow word dropped", 32'(expq.size()), 32'h0);

        // R6 transmit threshold
        wr(3'd2, 32'h0200);
        push_cmd(8'h51, 1'b0, 1'b0);
        push_cmd(8'h52, 1'b0, 1'b0);
        rd(3'd3, v); check("R6 TX_EMPTY at threshold", 32'(v[5]), 32'h1);
        push_cmd(8'h53, 1'b0, 1'b1);
        rd(3'd3, v); check("R6 TX_EMPTY above threshold", 32'(v[5]), 32'h0);
        drain();

        // R5, R3, R4 receive path
        wr(3'd2, 32'h0002);
        rx_in(8'hA0); rx_in(8'hA1);
        rd(3'd3, v); check("R5 RX_FULL at threshold", 32'(v[4]), 32'h0);
        rx_in(8'hA2);
        rd(3'd3, v); check("R5 RX_FULL above threshold", 32'(v[4]), 32'h1);
        rd(3'd6, v); check("R13 RX-not-empty", 32'(v[2]), 32'h1);
        wr(3'd1, 32'd1 << 11);
        rd(3'd1, v); check("R3 first pop", v, 32'hA0);
        rd(3'd3, v); check("R5 RX_FULL self-clears", 32'(v[4]), 32'h0);
        for (int i = 3; i < 9; i++) rx_in(8'(8'hA0 + i));
        rd(3'd7, v); check("R13 rx level", v, 32'h0800);
        rx_in(8'hEE);
        rd(3'd3, v); check("R4 RX_OVER", 32'(v[2]), 32'h1);
        for (int i = 1; i < 9; i++) begin
            wr(3'd1, 32'd1 << 11);
            rd(3'd1, v); check("R3 pop order", v, 32'(8'hA0 + i));
        end
        wr(3'd1, 32'd1 << 11);
        rd(3'd3, v); check("R3 RX_UNDER", 32'(v[1]), 32'h1);
        rd(3'd1, v); check("R3 byte unchanged on underflow", v, 32'hA8);

        // R10 mask and R11 clear-all
        wr(3'd4, 32'h0);
        check("R10 masked irq low", 32'(irq), 32'h0);
        rd(3'd3, v); check("R10 raw flags visible", v & 32'h7, 32'h7);
        wr(3'd4, 32'h4);
        check("R10 unmasked irq", 32'(irq), 32'h1);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd3, v); check("R11 all latched cleared", v & 32'hF, 32'h0);
        check("R11 irq low after clear", 32'(irq), 32'h0);

        // R7 user abort
        wr(3'd2, 32'h0);
        eng_idle = 1'b0;
        push_cmd(8'h61, 1'b0, 1'b0);
        push_cmd(8'h62, 1'b0, 1'b0);
        wr(3'd0, 32'h3);
        @(negedge clk);
        check("R7 no command while abort pending", 32'(cmd_valid), 32'h0);
        check("R7 abort_req", 32'(abort_req), 32'h1);
        rd(3'd7, v); check("R7 queue kept until idle", v, 32'h2);
        @(posedge clk); #1 eng_idle = 1'b1;
        @(posedge clk); #1;
        expq.delete();
        rd(3'd3, v); check("R7 TX_ABRT", 32'(v[3]), 32'h1);
        rd(3'd6, v); check("R7 user cause", v & 32'h700, 32'h100);
        rd(3'd0, v); check("R7 abort bit self-clears", v, 32'h1);
        rd(3'd7, v); check("R7 queue flushed", v, 32'h0);
        // R9 pushes refused while aborted
        wr(3'd1, (32'd1 << 10) | 32'h70);
        rd(3'd7, v); check("R9 push refused", v, 32'h0);
        rd(3'd3, v); check("R9 no TX_OVER", 32'(v[0]), 32'h0);
        wr(3'd5, 32'h8);
        rd(3'd6, v); check("R9 cause cleared", v & 32'h700, 32'h0);
        push_cmd(8'h71, 1'b1, 1'b1);
        rd(3'd7, v); check("R9 push after release", v, 32'h1);
        drain();
        check("R9 released command delivered", 32'(expq.size()), 32'h0);

        // R8 NACK and arbitration loss
        push_cmd(8'h81, 1'b0, 1'b0);
        @(posedge clk); #1 eng_nack = 1'b1;
        @(posedge clk); #1 eng_nack = 1'b0;
        expq.delete();
        rd(3'd3, v); check("R8 TX_ABRT on NACK", 32'(v[3]), 32'h1);
        rd(3'd6, v); check("R8 NACK cause", v & 32'h700, 32'h200);
        rd(3'd7, v); check("R8 flushed on NACK", v, 32'h0);
        wr(3'd5, 32'h8);
        @(posedge clk); #1 eng_arb_lost = 1'b1;
        @(posedge clk); #1 eng_arb_lost = 1'b0;
        rd(3'd6, v); check("R8 arbitration cause", v & 32'h700, 32'h400);
        wr(3'd5, 32'h8);

        // R12 disable waits for idle
        eng_idle = 1'b0;
        wr(3'd0, 32'h0);
        @(posedge clk); #1;
        rd(3'd6, v); check("R12 enable-status held while busy", 32'(v[4]), 32'h1);
        check("R13 busy", 32'(v[3]), 32'h1);
        eng_idle = 1'b1;
        @(posedge clk); #1;
        rd(3'd6, v); check("R12 enable-status falls when idle", 32'(v[4]), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule